// File: doc/BRIEF.md
# I2C Target Bridge to 32-bit Word Registers

The bridge is an I2C target that gives an external master read and write access to a bank of 32-bit registers through a plain parallel register port. A transfer opens with a control byte that holds the 7-bit device address and the direction bit. A write-direction transfer then carries one byte of word address, followed by data in groups of four bytes, most significant byte first. Each complete group of four bytes is committed as one register write. The address advances after every committed word and wraps to zero.

To read, the master sends a write-direction control byte and the address byte. It then issues a repeated start and a read-direction control byte, and clocks data out for as long as it acknowledges. A start or stop that arrives in the middle of a word ends the transfer at once. The partial word is discarded.

SDA and SCL are sampled on the system clock through a synchronizer. The open-drain pads are modelled as a line input plus an output enable that pulls the line low.

Top module: `i2c_word_bridge`

## Requirements
- R1: A control byte whose upper seven bits equal DEV_ADDR is acknowledged. Its bit 0 selects the direction: 0 means write, 1 means read. A control byte with any other address is not acknowledged, and the bytes that follow up to the next start or stop are neither acknowledged nor written.
- R2: In a write transfer, the first byte after the control byte loads the 8-bit word address. The word address is presented on reg_addr_o.
- R3: Four data bytes are assembled MSB first into one 32-bit word: the first byte goes to bits 31:24 and the last to bits 7:0. The word is written with a single-cycle reg_we_o pulse only after the fourth byte.
- R4: In a write transfer addressed to this target, the target pulls SDA low during the ninth clock of every byte: the control byte, the address byte and each data byte.
- R5: A start or stop before the fourth data byte of a word is complete discards that word. No write occurs, and the address keeps its value.
- R6: Data bytes that continue past a completed word write the next word address, one register per four bytes.
- R7: The address increments after every committed write, including the last one. A read that follows without a new address byte starts at the incremented address.
- R8: Word address 255 advances to 0.
- R9: A read transfer is a repeated start followed by a read-direction control byte. The target returns the word at the current address MSB first, strobing reg_re_o when it fetches the word. Each master acknowledge continues the stream, and the address advances after every fourth byte.
- R10: After a master not-acknowledge on a read byte, the target releases SDA and drives nothing until the next start or stop.
- R11: Out of reset, SDA is released and neither reg_we_o nor reg_re_o is asserted. The two strobes are never asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| reg_addr_o | output | AW | Register word address |
| reg_wdata_o | output | DW | Register write data |
| reg_we_o | output | 1 | Register write strobe, one cycle |
| reg_re_o | output | 1 | Register read strobe, one cycle |
| reg_rdata_i | input | DW | Register read data for reg_addr_o, combinational |

## Verification
Single-word and three-word writes separate the commit of one word from address advance between words. A two-word write starting at address 255 shows the wrap. Transfers aborted by a stop after two data bytes, and by a repeated start after three data bytes, show that partial words leave both the register and the address untouched. A multi-word read ended by a not-acknowledge checks byte order, the address step between words and the release of SDA. A read with no address byte after a write shows the post-write increment, and a control byte with a foreign address shows that the target stays silent.

// File: rtl/i2c_bridge_pkg.sv
package i2c_bridge_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CTRL, ST_ADDR, ST_WDATA, ST_ACK, ST_RDATA, ST_RACK, ST_WAIT
  } bridge_st_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] scl_ff, sda_ff;
  logic         scl_d, sda_d, scl_s, sda_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[MSB-1:0], scl_i};
      sda_ff <= {sda_ff[MSB-1:0], sda_i};
      scl_d  <= scl_ff[MSB];
      sda_d  <= sda_ff[MSB];
    end
  end

  assign scl_s      = scl_ff[MSB];
  assign sda_s      = sda_ff[MSB];
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_d;
  assign scl_fall_o = ~scl_s & scl_d;
  // SDA edge while SCL stays high
  assign start_o    = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_o     = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_word_addr.sv
module i2c_word_addr #(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          inc_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (load_i) addr_q <= load_val_i;
    else if (inc_i)  addr_q <= addr_q + 1'b1;
  end

  assign addr_o = addr_q;

  a_r8_wrap_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !load_i && addr_q == '1) |=> (addr_q == '0));

  a_r6_step_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !load_i) |=> (addr_q == AW'($past(addr_q) + 1)));
endmodule

// File: rtl/i2c_word_bridge.sv
module i2c_word_bridge
  import i2c_bridge_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h2A,
  parameter int         AW          = 8,
  parameter int         DW          = 32,
  parameter int         SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  output logic [AW-1:0] reg_addr_o,
  output logic [DW-1:0] reg_wdata_o,
  output logic          reg_we_o,
  output logic          reg_re_o,
  input  logic [DW-1:0] reg_rdata_i
);
  localparam int          BYTES  = DW / 8;
  localparam int          BW     = (BYTES > 1) ? $clog2(BYTES) : 1;
  localparam logic [BW-1:0] LAST_B = BW'(BYTES - 1);

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_o     (sda_s),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_det),
    .stop_o    (stop_det)
  );

  bridge_st_e    st_q, nxt_q;
  logic [3:0]    cnt_q;
  logic [BW-1:0] bcnt_q;
  logic [DW-1:0] sh_q, rsh_q;
  logic          oe_q, mack_q;

  logic byte_done, commit, addr_load, rd_load, rd_inc;
  logic [AW-1:0] addr;

  assign byte_done = (cnt_q == 4'd8) && scl_fall;
  assign commit    = (st_q == ST_WDATA) && byte_done && (bcnt_q == LAST_B);
  assign addr_load = (st_q == ST_ADDR) && byte_done;
  assign rd_load   = ((st_q == ST_ACK) && scl_fall && (nxt_q == ST_RDATA)) ||
                     ((st_q == ST_RACK) && scl_fall && mack_q && (bcnt_q == '0));
  assign rd_inc    = (st_q == ST_RDATA) && scl_fall && (cnt_q == 4'd7) && (bcnt_q == LAST_B);

  i2c_word_addr #(.AW(AW)) u_addr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (addr_load),
    .load_val_i(sh_q[AW-1:0]),
    .inc_i     (commit | rd_inc),
    .addr_o    (addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      nxt_q  <= ST_IDLE;
      cnt_q  <= '0;
      bcnt_q <= '0;
      sh_q   <= '0;
      rsh_q  <= '0;
      oe_q   <= 1'b0;
      mack_q <= 1'b0;
    end else if (stop_det) begin
      st_q <= ST_IDLE;
      oe_q <= 1'b0;
    end else if (start_det) begin
      st_q  <= ST_CTRL;
      cnt_q <= '0;
      oe_q  <= 1'b0;
    end else begin
      unique case (st_q)
        ST_CTRL, ST_ADDR, ST_WDATA: begin
          if (scl_rise && cnt_q < 4'd8) begin
            sh_q  <= {sh_q[DW-2:0], sda_s};
            cnt_q <= cnt_q + 1'b1;
          end else if (byte_done) begin
            cnt_q <= '0;
            if (st_q == ST_CTRL) begin
              if (sh_q[7:1] == DEV_ADDR) begin
                oe_q   <= 1'b1;
                st_q   <= ST_ACK;
                nxt_q  <= sh_q[0] ? ST_RDATA : ST_ADDR;
                bcnt_q <= '0;
              end else begin
                st_q <= ST_WAIT;
              end
            end else begin
              oe_q   <= 1'b1;
              st_q   <= ST_ACK;
              nxt_q  <= ST_WDATA;
              bcnt_q <= (st_q == ST_ADDR) ? '0 : bcnt_q + 1'b1;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            cnt_q <= '0;
            st_q  <= nxt_q;
            if (nxt_q == ST_RDATA) begin
              rsh_q <= reg_rdata_i;
              oe_q  <= ~reg_rdata_i[DW-1];
            end else begin
              oe_q <= 1'b0;
            end
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            rsh_q <= {rsh_q[DW-2:0], 1'b0};
            if (cnt_q == 4'd7) begin
              st_q   <= ST_RACK;
              cnt_q  <= '0;
              oe_q   <= 1'b0;
              bcnt_q <= bcnt_q + 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
              oe_q  <= ~rsh_q[DW-2];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) mack_q <= ~sda_s;
          if (scl_fall) begin
            if (mack_q) begin
              st_q <= ST_RDATA;
              if (bcnt_q == '0) begin
                rsh_q <= reg_rdata_i;
                oe_q  <= ~reg_rdata_i[DW-1];
              end else begin
                oe_q <= ~rsh_q[DW-1];
              end
            end else begin
              st_q <= ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o    = oe_q;
  assign reg_addr_o  = addr;
  assign reg_wdata_o = sh_q;
  assign reg_we_o    = commit;
  assign reg_re_o    = rd_load;

  a_r3_we_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);

  a_r7_inc_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> (reg_addr_o == AW'($past(reg_addr_o) + 1)));

  a_r10_stop_releases_sda: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sda_oe_o);

  a_r5_no_write_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> !reg_we_o);

  a_r11_strobes_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_o && reg_re_o));
endmodule

// File: tb/i2c_word_bridge_bench.sv
module i2c_word_bridge_bench;
  localparam logic [6:0] DEV = 7'h2A;
  localparam int Q = 10;
  localparam int H = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl = 1'b1;
  logic        sda_m = 1'b1;
  logic        sda_oe;
  logic        sda_line;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        reg_we, reg_re;
  logic [31:0] regs [256];
  int          we_cnt;
  int          checks = 0;
  int          errors = 0;

  always #5 clk = ~clk;

  assign sda_line  = sda_m & ~sda_oe;
  assign reg_rdata = regs[reg_addr];

  i2c_word_bridge u_i2c_word_bridge (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .scl_i      (scl),
    .sda_i      (sda_line),
    .sda_oe_o   (sda_oe),
    .reg_addr_o (reg_addr),
    .reg_wdata_o(reg_wdata),
    .reg_we_o   (reg_we),
    .reg_re_o   (reg_re),
    .reg_rdata_i(reg_rdata)
  );

  function automatic logic [31:0] pat(input int i);
    return {8'h5A, 8'(i), ~8'(i), 8'h3C};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) regs[i] <= pat(i);
      we_cnt <= 0;
    end else if (reg_we) begin
      regs[reg_addr] <= reg_wdata;
      we_cnt <= we_cnt + 1;
    end
  end

  task automatic wc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wc(Q); scl = 1'b1; wc(Q); sda_m = 1'b0; wc(Q); scl = 1'b0; wc(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wc(Q); scl = 1'b1; wc(Q); sda_m = 1'b1; wc(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wc(Q); scl = 1'b1; wc(H); scl = 1'b0; wc(Q);
    end
    sda_m = 1'b1; wc(Q); scl = 1'b1; wc(H/2);
    ack = ~sda_line;
    wc(H/2); scl = 1'b0; wc(Q);
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic ack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wc(Q); scl = 1'b1; wc(H/2); b[i] = sda_line; wc(H/2); scl = 1'b0;
    end
    sda_m = ~ack; wc(Q); scl = 1'b1; wc(H); scl = 1'b0; wc(Q); sda_m = 1'b1;
  endtask

  // returns number of acknowledged bytes
  task automatic send_word(input logic [31:0] w, inout int acks);
    logic a;
    for (int i = 3; i >= 0; i--) begin
      send_byte(w[i*8 +: 8], a);
      if (a) acks++;
    end
  endtask

  task automatic recv_word(output logic [31:0] w, input logic last);
    logic [7:0] b;
    for (int i = 3; i >= 0; i--) begin
      recv_byte(b, !(last && i == 0));
      w[i*8 +: 8] = b;
    end
  endtask

  task automatic t_reset();
    check("R11 sda released", 32'(sda_oe), 0);
    check("R11 no strobes", {30'd0, reg_we, reg_re}, 0);
  endtask

  task automatic t_single_write();
    logic a; int acks = 0; int c0 = we_cnt;
    i2c_start();
    send_byte({DEV, 1'b0}, a); check("R1 control ack", 32'(a), 1);
    send_byte(8'h10, a); if (a) acks++;
    send_word(32'hDEADBEEF, acks);
    i2c_stop();
    check("R4 acks on addr+data", acks, 5);
    check("R2 R3 word at 0x10", regs[8'h10], 32'hDEADBEEF);
    check("R3 one write strobe", we_cnt - c0, 1);
  endtask

  task automatic t_multi_write();
    logic a; int acks = 0;
    i2c_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h20, a);
    send_word(32'h11223344, acks);
    send_word(32'h55667788, acks);
    send_word(32'h99AABBCC, acks);
    i2c_stop();
    check("R6 word 0x20", regs[8'h20], 32'h11223344);
    check("R6 word 0x21", regs[8'h21], 32'h55667788);
    check("R6 word 0x22", regs[8'h22], 32'h99AABBCC);
    check("R6 next untouched", regs[8'h23], pat(8'h23));
  endtask

  task automatic t_wrap();
    logic a; int acks = 0;
    i2c_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'hFF, a);
    send_word(32'hF00DCAFE, acks);
    send_word(32'h0BADC0DE, acks);
    i2c_stop();
    check("R8 word 0xFF", regs[8'hFF], 32'hF00DCAFE);
    check("R8 wrapped to 0x00", regs[8'h00], 32'h0BADC0DE);
  endtask

  task automatic t_abort_stop();
    logic a; int c0 = we_cnt;
    i2c_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h30, a);
    send_byte(8'hAB, a);
    send_byte(8'hCD, a);
    i2c_stop();
    check("R5 stop keeps reg", regs[8'h30], pat(8'h30));
    check("R5 stop no strobe", we_cnt - c0, 0);
  endtask

  task automatic t_abort_start();
    logic a; logic [31:0] w; int c0 = we_cnt;
    i2c_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h31, a);
    send_byte(8'h01, a);
    send_byte(8'h02, a);
    send_byte(8'h03, a);
    i2c_start();
    send_byte({DEV, 1'b1}, a); check("R9 read control ack", 32'(a), 1);
    recv_word(w, 1'b1);
    i2c_stop();
    check("R5 start no strobe", we_cnt - c0, 0);
    check("R5 address kept, reg intact", w, pat(8'h31));
  endtask

  task automatic t_read_seq();
    logic a; logic [31:0] w0, w1;
    i2c_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h20, a);
    i2c_start();
    send_byte({DEV, 1'b1}, a);
    recv_word(w0, 1'b0);
    recv_word(w1, 1'b1);
    wc(Q);
    check("R10 released after nack", 32'(sda_oe), 0);
    wc(H);
    check("R10 still released", 32'(sda_oe), 0);
    i2c_stop();
    check("R9 first word", w0, 32'h11223344);
    check("R9 second word", w1, 32'h55667788);
  endtask

  task automatic t_read_after_write();
    logic a; int acks = 0; logic [31:0] w;
    i2c_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h40, a);
    send_word(32'hCAFEF00D, acks);
    i2c_stop();
    i2c_start();
    send_byte({DEV, 1'b1}, a);
    recv_word(w, 1'b1);
    i2c_stop();
    check("R7 read from incremented addr", w, pat(8'h41));
  endtask

  task automatic t_wrong_addr();
    logic a; int acks = 0; int c0 = we_cnt;
    i2c_start();
    send_byte({7'h15, 1'b0}, a); check("R1 foreign address nack", 32'(a), 0);
    send_byte(8'h50, a); if (a) acks++;
    send_word(32'h12345678, acks);
    i2c_stop();
    check("R1 foreign bytes not acked", acks, 0);
    check("R1 foreign no write", we_cnt - c0, 0);
    check("R1 reg 0x50 intact", regs[8'h50], pat(8'h50));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wc(4);
    rst_n = 1'b1;
    wc(4);
    t_reset();
    t_single_write();
    t_multi_write();
    t_wrap();
    t_abort_stop();
    t_abort_start();
    t_read_seq();
    t_read_after_write();
    t_wrong_addr();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule